// File: doc/BRIEF.md
# Indexed IDE Controller Configuration Bank

This block holds the byte-wide configuration registers of a dual-channel IDE host controller and makes them reachable through two ports on a local bus. The host writes a register number into the index port. It then reads or writes that register through the data port, which sits four byte addresses above the index port. Every access is a single byte. An access flagged as wider than a byte is dropped.

The bank holds the following registers:
- identity bytes, read-only;
- a configuration byte, read-only, carrying the silicon revision and an alternate-base flag;
- a control byte with the secondary-channel enable and the prefetch disables for drives 0 and 1;
- a command-block timing byte;
- address-setup and read/write timing bytes for drive 0, for drive 1, and one shared pair for drives 2/3;
- a burst-size byte;
- a scratch byte that software uses to confirm the part is present.

The shared drives-2/3 setup byte also carries the prefetch disables for drives 2 and 3. The stored values drive the timing generator and the prefetch logic as plain outputs.

Access is sequenced by a two-state machine. From reset it sits in ST_IDLE. Any read request moves it to ST_RD_RESP, where the captured byte is presented with `bus_rvalid` high. It stays in ST_RD_RESP for back-to-back reads. It returns to ST_IDLE from either state when the cycle carries no read. Writes commit at the clock edge that samples them and do not leave ST_IDLE.

Top module: `ide_cfg_bank`

## Requirements
- R1: After reset the outputs hold their reset values:
  - `bus_rvalid` is 0 and `sec_enable` is 0;
  - `pf_disable` is 4'hF;
  - `cmd_timing`, `setup_code` and `rw_timing` are all 0 (slowest encodings);
  - `burst_size` is 8'h40;
  - the scratch register at index 8'h5B reads 8'h00.
- R2: A write with `bus_addr`=0 stores `bus_wdata` as the current index. A read with `bus_addr`=0 returns the current index.
- R3: A read request (`bus_cs`=1, `bus_we`=0) in cycle N gives `bus_rvalid`=1 with the read byte on `bus_rdata` in cycle N+1 only. A write with `bus_addr`=4 updates the register selected by the current index.
- R4: Indexes 8'h00..8'h03 read 8'h95, 8'h10, 8'h40, 8'h06 in that order. Writes to them are ignored.
- R5: Index 8'h50 reads 8'h02 with default parameters: bit 5 is the alternate-base flag (0) and bits [1:0] the revision (2). Writes to it are ignored.
- R6: For the control byte at index 8'h51, bit 3 drives `sec_enable`, bit 6 drives `pf_disable[0]` and bit 7 drives `pf_disable[1]`. The outputs follow one cycle after the write.
- R7: For the shared drives-2/3 setup byte at index 8'h57, bit 2 drives `pf_disable[2]`, bit 3 drives `pf_disable[3]`, and bits [7:6] drive `setup_code[5:4]`.
- R8: The timing outputs map as follows:
  - bits [7:6] of index 8'h53 drive `setup_code[1:0]`; bits [7:6] of index 8'h55 drive `setup_code[3:2]`;
  - indexes 8'h54, 8'h56 and 8'h58 drive `rw_timing` bytes 0, 1 and 2;
  - index 8'h52 drives `cmd_timing`; index 8'h59 drives `burst_size`;
  - all of these bytes read back what was written.
- R9: Index 8'h5B reads back exactly the last byte written to it.
- R10: Any index not listed in R4 to R9 reads 8'hFF, and writes to it change nothing.
- R11: An access with `bus_wide`=1 changes neither the index nor any register. A wide read returns 8'hFF.
- R12: An access with `bus_addr` other than 0 or 4 changes nothing. A read at such an address returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Access is wider than one byte (dropped) |
| bus_addr | input | 3 | Port offset: 0 index port, 4 data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after the request |
| sec_enable | output | 1 | Secondary channel enable |
| pf_disable | output | 4 | Prefetch disable per drive, bit n = drive n |
| cmd_timing | output | 8 | Command-block timing byte |
| setup_code | output | 6 | Address-setup codes: drive 0, drive 1, drives 2/3 |
| rw_timing | output | 24 | Read/write timing bytes: drive 0, drive 1, drives 2/3 |
| burst_size | output | 8 | Prefetch burst-size byte |

## Verification
Every result has a fixed latency of one edge:
- register and index updates are visible from the cycle after the write;
- read data and `bus_rvalid` appear in the cycle after the read request and last one cycle.

The bench drives inputs just after the falling edge. It samples all outputs on the next falling edge, after the single rising edge that produces them, and compares them with a behavioural model advanced on that same rising edge. Directed reads check their byte in exactly that response cycle, before the next request is driven.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RD_RESP = 1'b1
    } acc_state_t;

    localparam int          NUM_SLOTS  = 10;
    localparam int          BYTE_W     = 8;
    localparam int          TIM_GROUPS = 3;
    localparam int          NUM_DRIVES = 4;
    localparam logic [7:0]  IX_CFG     = 8'h50;
    localparam logic [7:0]  IX_RUN_LO  = 8'h51;
    localparam logic [7:0]  IX_SCRATCH = 8'h5B;
    localparam logic [7:0]  RD_EMPTY   = 8'hFF;

    // slot 0 control, 1 cmd timing, 2..7 setup/rw pairs, 8 burst, 9 scratch
    localparam int SLOT_CTRL  = 0;
    localparam int SLOT_CMD   = 1;
    localparam int SLOT_BURST = 8;

    function automatic logic [7:0] slot_index(input int s);
        if (s == NUM_SLOTS - 1)
            return IX_SCRATCH;
        return 8'(int'(IX_RUN_LO) + s);
    endfunction

    function automatic logic [7:0] slot_reset(input int s);
        case (s)
            0:       return 8'hC0;   // prefetch off for drives 0/1, secondary off
            6:       return 8'h0C;   // prefetch off for drives 2/3, slowest setup
            8:       return 8'h40;   // 512-byte burst
            default: return 8'h00;   // slowest timing, scratch cleared
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h95;
            2'd1:    return 8'h10;
            2'd2:    return 8'h40;
            default: return 8'h06;
        endcase
    endfunction

endpackage

// File: rtl/ide_cfg_access_fsm.sv
module ide_cfg_access_fsm
    import ide_cfg_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int INDEX_PORT  = 0,
    parameter int DATA_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        reg_rd_data,
    output logic [7:0]        cur_idx,
    output logic              reg_wr_en,
    output logic [7:0]        reg_wr_data,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid
);
    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(INDEX_PORT);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(INDEX_PORT + DATA_OFFSET);

    acc_state_t state_q, state_d;
    logic       byte_ok, at_index, at_data, rd_req;
    logic [7:0] rd_value;

    assign byte_ok     = bus_cs && !bus_wide;
    assign at_index    = bus_addr == A_INDEX;
    assign at_data     = bus_addr == A_DATA;
    assign rd_req      = bus_cs && !bus_we;
    assign reg_wr_en   = byte_ok && bus_we && at_data;
    assign reg_wr_data = bus_wdata;

    always_comb begin
        if (byte_ok && at_index)
            rd_value = cur_idx;
        else if (byte_ok && at_data)
            rd_value = reg_rd_data;
        else
            rd_value = RD_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = rd_req ? ST_RD_RESP : ST_IDLE;
            ST_RD_RESP: state_d = rd_req ? ST_RD_RESP : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and index latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx   <= 8'h00;
            bus_rdata <= 8'h00;
        end else begin
            if (byte_ok && bus_we && at_index)
                cur_idx <= bus_wdata;
            if (rd_req)
                bus_rdata <= rd_value;
        end
    end

    assign bus_rvalid = state_q == ST_RD_RESP;

endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
    import ide_cfg_pkg::*;
#(
    parameter logic [1:0] REVISION = 2'd2,
    parameter bit         ALT_BASE = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [7:0]                  wr_idx,
    input  logic [7:0]                  wr_data,
    input  logic [7:0]                  rd_idx,
    output logic [7:0]                  rd_data,
    output logic [NUM_SLOTS-1:0][7:0]   store
);
    localparam logic [7:0] CFG_VALUE = {2'b00, ALT_BASE, 3'b000, REVISION};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [7:0] MY_IDX = slot_index(s);
        localparam logic [7:0] MY_RST = slot_reset(s);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store[s] <= MY_RST;
            else if (wr_en && wr_idx == MY_IDX)
                store[s] <= wr_data;
        end
    end

    always_comb begin
        rd_data = RD_EMPTY;
        if (rd_idx < 8'd4)
            rd_data = ident_byte(rd_idx[1:0]);
        else if (rd_idx == IX_CFG)
            rd_data = CFG_VALUE;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (rd_idx == slot_index(s))
                rd_data = store[s];
    end

endmodule

// File: rtl/ide_cfg_timing_view.sv
module ide_cfg_timing_view
    import ide_cfg_pkg::*;
(
    input  logic [NUM_SLOTS-1:0][7:0]      store,
    output logic                           sec_enable,
    output logic [NUM_DRIVES-1:0]          pf_disable,
    output logic [7:0]                     cmd_timing,
    output logic [2*TIM_GROUPS-1:0]        setup_code,
    output logic [BYTE_W*TIM_GROUPS-1:0]   rw_timing,
    output logic [7:0]                     burst_size
);
    localparam int SLOT_SHARED = 2 + 2 * (TIM_GROUPS - 1);

    logic unused_bits;

    assign sec_enable = store[SLOT_CTRL][3];
    assign cmd_timing = store[SLOT_CMD];
    assign burst_size = store[SLOT_BURST];

    for (genvar g = 0; g < TIM_GROUPS; g++) begin : g_grp
        assign setup_code[2*g +: 2]     = store[2 + 2*g][7:6];
        assign rw_timing[BYTE_W*g +: 8] = store[3 + 2*g];
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        if (d < 2) begin : g_pri
            assign pf_disable[d] = store[SLOT_CTRL][6 + d];
        end else begin : g_sec
            assign pf_disable[d] = store[SLOT_SHARED][d];
        end
    end

    assign unused_bits = ^{store[SLOT_CTRL][2:0], store[SLOT_CTRL][5:4],
                           store[2][5:0], store[4][5:0],
                           store[SLOT_SHARED][5:4], store[SLOT_SHARED][1:0],
                           store[NUM_SLOTS-1]};

endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
    import ide_cfg_pkg::*;
#(
    parameter int         ADDR_W      = 3,
    parameter int         INDEX_PORT  = 0,
    parameter int         DATA_OFFSET = 4,
    parameter logic [1:0] REVISION    = 2'd2,
    parameter bit         ALT_BASE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic              sec_enable,
    output logic [3:0]        pf_disable,
    output logic [7:0]        cmd_timing,
    output logic [5:0]        setup_code,
    output logic [23:0]       rw_timing,
    output logic [7:0]        burst_size
);
    logic [7:0]                cur_idx;
    logic                      reg_wr_en;
    logic [7:0]                reg_wr_data;
    logic [7:0]                reg_rd_data;
    logic [NUM_SLOTS-1:0][7:0] store;

    ide_cfg_access_fsm #(
        .ADDR_W      (ADDR_W),
        .INDEX_PORT  (INDEX_PORT),
        .DATA_OFFSET (DATA_OFFSET)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_cs      (bus_cs),
        .bus_we      (bus_we),
        .bus_wide    (bus_wide),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .reg_rd_data (reg_rd_data),
        .cur_idx     (cur_idx),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid)
    );

    ide_cfg_regfile #(
        .REVISION (REVISION),
        .ALT_BASE (ALT_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_idx  (cur_idx),
        .wr_data (reg_wr_data),
        .rd_idx  (cur_idx),
        .rd_data (reg_rd_data),
        .store   (store)
    );

    ide_cfg_timing_view u_view (
        .store      (store),
        .sec_enable (sec_enable),
        .pf_disable (pf_disable),
        .cmd_timing (cmd_timing),
        .setup_code (setup_code),
        .rw_timing  (rw_timing),
        .burst_size (burst_size)
    );

endmodule

// File: rtl/ide_cfg_bank_chk.sv
module ide_cfg_bank_chk #(
    parameter int ADDR_W      = 3,
    parameter int INDEX_PORT  = 0,
    parameter int DATA_OFFSET = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_we,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              bus_rvalid,
    input logic              sec_enable,
    input logic [3:0]        pf_disable,
    input logic [7:0]        burst_size,
    input logic [7:0]        cur_idx
);
    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(INDEX_PORT);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(INDEX_PORT + DATA_OFFSET);

    assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we) |=> bus_rvalid);

    assert_rvalid_only_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && !bus_we) |=> !bus_rvalid);

    assert_index_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !bus_wide && bus_addr == A_INDEX) |=> bus_rdata == $past(cur_idx));

    assert_wide_read_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && bus_wide) |=> bus_rdata == 8'hFF);

    assert_wide_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wide) |=> ($stable(cur_idx) && $stable(burst_size)));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_we && !bus_wide && bus_addr == A_DATA)
        |=> ($stable(pf_disable) && $stable(sec_enable)));

    assert_bad_port_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !bus_wide && bus_addr != A_INDEX && bus_addr != A_DATA)
        |=> bus_rdata == 8'hFF);

endmodule

bind ide_cfg_bank ide_cfg_bank_chk #(
    .ADDR_W      (ADDR_W),
    .INDEX_PORT  (INDEX_PORT),
    .DATA_OFFSET (DATA_OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs     (bus_cs),
    .bus_we     (bus_we),
    .bus_wide   (bus_wide),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .sec_enable (sec_enable),
    .pf_disable (pf_disable),
    .burst_size (burst_size),
    .cur_idx    (cur_idx)
);

// File: tb/sim_ide_cfg_bank.sv
`timescale 1ns/1ps
module sim_ide_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid, sec_enable;
    logic [3:0]  pf_disable;
    logic [7:0]  cmd_timing, burst_size;
    logic [5:0]  setup_code;
    logic [23:0] rw_timing;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ide_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .sec_enable(sec_enable),
        .pf_disable(pf_disable), .cmd_timing(cmd_timing), .setup_code(setup_code),
        .rw_timing(rw_timing), .burst_size(burst_size)
    );

    // ---------------- behavioural reference model ----------------
    int m_mem[256];
    int m_idx;
    int m_rvalid;
    int m_rdata;

    function automatic bit m_writable(int i);
        return (i >= 'h51 && i <= 'h59) || i == 'h5B;
    endfunction

    task automatic m_reset();
        foreach (m_mem[i]) m_mem[i] = 'hFF;
        m_mem[0] = 'h95; m_mem[1] = 'h10; m_mem[2] = 'h40; m_mem[3] = 'h06;
        m_mem['h50] = 'h02;
        for (int i = 'h51; i <= 'h58; i++) m_mem[i] = 0;
        m_mem['h51] = 'hC0;
        m_mem['h57] = 'h0C;
        m_mem['h59] = 'h40;
        m_mem['h5B] = 0;
        m_idx = 0; m_rvalid = 0; m_rdata = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            m_rvalid = 0;
            if (bus_cs && !bus_we) begin
                m_rvalid = 1;
                if (bus_wide)             m_rdata = 'hFF;
                else if (bus_addr == 0)   m_rdata = m_idx;
                else if (bus_addr == 4)   m_rdata = m_mem[m_idx];
                else                      m_rdata = 'hFF;
            end else if (bus_cs && bus_we && !bus_wide) begin
                if (bus_addr == 0) m_idx = bus_wdata;
                else if (bus_addr == 4 && m_writable(m_idx)) m_mem[m_idx] = bus_wdata;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 rvalid", int'(bus_rvalid), m_rvalid);
            if (m_rvalid != 0) check("R3 rdata", int'(bus_rdata), m_rdata);
            check("R6 sec_enable", int'(sec_enable), (m_mem['h51] >> 3) & 1);
            check("R6 R7 pf_disable", int'(pf_disable),
                  (((m_mem['h57] >> 3) & 1) << 3) | (((m_mem['h57] >> 2) & 1) << 2) |
                  (((m_mem['h51] >> 7) & 1) << 1) | ((m_mem['h51] >> 6) & 1));
            check("R8 cmd_timing", int'(cmd_timing), m_mem['h52]);
            check("R8 burst_size", int'(burst_size), m_mem['h59]);
            check("R7 R8 setup_code", int'(setup_code),
                  ((m_mem['h57] >> 6) << 4) | ((m_mem['h55] >> 6) << 2) | (m_mem['h53] >> 6));
            check("R8 rw_timing", int'(rw_timing),
                  (m_mem['h58] << 16) | (m_mem['h56] << 8) | m_mem['h54]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(bit cs, bit we, bit wide, logic [2:0] a, logic [7:0] d);
        @(negedge clk); #1;
        bus_cs = cs; bus_we = we; bus_wide = wide; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 3'd0, 8'h00);
    endtask

    task automatic wr_reg(logic [7:0] idx, logic [7:0] val);
        cyc(1, 1, 0, 3'd0, idx);
        cyc(1, 1, 0, 3'd4, val);
        idle();
    endtask

    task automatic rd_reg(logic [7:0] idx, int exp, string tag);
        cyc(1, 1, 0, 3'd0, idx);
        cyc(1, 0, 0, 3'd4, 8'h00);
        @(negedge clk);
        check(tag, int'(bus_rdata), exp);
        #1 bus_cs = 0;
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 rvalid", int'(bus_rvalid), 0);
        check("R1 pf_disable", int'(pf_disable), 'hF);
        check("R1 sec_enable", int'(sec_enable), 0);
        check("R1 burst", int'(burst_size), 'h40);
        check("R1 timing", int'(rw_timing) | int'(setup_code) | int'(cmd_timing), 0);
        rd_reg(8'h5B, 'h00, "R1 scratch reset");
        // R4 identity
        rd_reg(8'h00, 'h95, "R4 id0");
        rd_reg(8'h01, 'h10, "R4 id1");
        rd_reg(8'h02, 'h40, "R4 id2");
        rd_reg(8'h03, 'h06, "R4 id3");
        wr_reg(8'h01, 8'h00);
        rd_reg(8'h01, 'h10, "R4 id write ignored");
        // R5 config
        rd_reg(8'h50, 'h02, "R5 config");
        wr_reg(8'h50, 8'hFF);
        rd_reg(8'h50, 'h02, "R5 config write ignored");
        // R2 index readback
        cyc(1, 1, 0, 3'd0, 8'hA7);
        cyc(1, 0, 0, 3'd0, 8'h00);
        @(negedge clk); check("R2 index readback", int'(bus_rdata), 'hA7);
        idle();
        // R6 control
        wr_reg(8'h51, 8'h08);
        check("R6 sec_enable", int'(sec_enable), 1);
        check("R6 pf drives 0/1", int'(pf_disable), 'hC);
        wr_reg(8'h51, 8'h40);
        check("R6 pf drive0", int'(pf_disable), 'hD);
        // R7 shared register
        wr_reg(8'h57, 8'h84);
        check("R7 pf drive2 only", int'(pf_disable), 'h5);
        check("R7 setup code 2/3", int'(setup_code[5:4]), 2);
        // R8 timing bytes
        wr_reg(8'h53, 8'h40); wr_reg(8'h55, 8'hC0);
        wr_reg(8'h54, 8'h21); wr_reg(8'h56, 8'h43); wr_reg(8'h58, 8'h65);
        wr_reg(8'h52, 8'h00); wr_reg(8'h59, 8'h80);
        check("R8 setup_code", int'(setup_code), 'h2D);
        check("R8 rw_timing", int'(rw_timing), 'h654321);
        check("R8 burst", int'(burst_size), 'h80);
        rd_reg(8'h56, 'h43, "R8 readback");
        // R9 scratch
        wr_reg(8'h5B, 8'hBD);
        rd_reg(8'h5B, 'hBD, "R9 scratch");
        wr_reg(8'h5B, 8'h00);
        rd_reg(8'h5B, 'h00, "R9 scratch clear");
        // R10 unimplemented
        wr_reg(8'h5A, 8'h12);
        rd_reg(8'h5A, 'hFF, "R10 idx 5A");
        rd_reg(8'h04, 'hFF, "R10 idx 04");
        rd_reg(8'hFF, 'hFF, "R10 idx FF");
        // R11 wide access
        cyc(1, 1, 0, 3'd0, 8'h59);
        cyc(1, 1, 1, 3'd4, 8'h11);
        cyc(1, 1, 1, 3'd0, 8'h52);
        cyc(1, 0, 1, 3'd4, 8'h00);
        @(negedge clk); check("R11 wide read", int'(bus_rdata), 'hFF);
        check("R11 wide write ignored", int'(burst_size), 'h80);
        idle();
        rd_reg(8'h59, 'h80, "R11 burst kept");
        // R12 other port address
        cyc(1, 1, 0, 3'd0, 8'h52);
        cyc(1, 1, 0, 3'd2, 8'h77);
        cyc(1, 0, 0, 3'd6, 8'h00);
        @(negedge clk); check("R12 bad port read", int'(bus_rdata), 'hFF);
        check("R12 bad port write ignored", int'(cmd_timing), 'h00);
        // R3 back-to-back reads
        cyc(1, 0, 0, 3'd0, 8'h00);
        cyc(1, 0, 0, 3'd4, 8'h00);
        @(negedge clk); check("R3 b2b rvalid", int'(bus_rvalid), 1);
        idle();
        // mixed random traffic compared by the model each cycle
        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 9);
            logic [2:0] a = (pick < 4) ? 3'd0 : (pick < 9) ? 3'd4 : 3'($urandom_range(0, 7));
            logic [7:0] d = (a == 3'd0) ? 8'($urandom_range('h4E, 'h5D)) : 8'($urandom);
            cyc($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 15) == 0, a, d);
        end
        idle();
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule